// File: doc/BRIEF.md
# Wiper Position Counter and Tap Decoder

This block holds the wiper position of one digitally controlled potentiometer. The resistor chain has 63 series segments and 64 tap switches: one switch at each end and one between each pair of neighbouring segments. A 6-bit position register picks exactly one of those 64 switches. The block drives them through a registered one-hot enable vector, so the analog switches only ever see clean, single-bit patterns.

There are four ways to change the position:

- A direct write takes effect on the next clock edge.
- A transfer load copies a value supplied from one of the associated data registers. It takes effect only after a settling delay, set by a parameter in system clocks, so that the wiper has time to respond.
- A step-up pulse moves the wiper one segment toward the high terminal.
- A step-down pulse moves it one segment toward the low terminal.

Stepping saturates at both ends of the chain and never wraps. The surrounding serial-command logic drives the inputs of this block, with one instance per potentiometer.

Top module: `wiper_tap_unit`

## Requirements
- R1: A synchronous active-high reset sets the position to 0, sets tap_en to bit 0 only, and drops any pending transfer.
- R2: tap_en always has exactly one bit set, and that bit is bit number wiper_pos. Tap k is bit k: bit 0 is the low end and bit 63 is the high end.
- R3: When wr_valid is high at a clock edge, wiper_pos becomes wr_data on that edge.
- R4: A transfer request (xfr_req high at an edge, value on xfr_data) loads the value exactly SETTLE_CYC edges after the request edge. Until that edge, the request itself leaves the position unchanged.
- R5: A new transfer request while one is pending replaces the pending value and restarts the full delay from the new request edge.
- R6: A direct write cancels any pending transfer, and that transfer is then never applied.
- R7: A step_up pulse alone adds one to the position, and a step_dn pulse alone subtracts one, each on the edge where it is sampled.
- R8: Stepping saturates: step_up at 63 keeps 63, and step_dn at 0 keeps 0.
- R9: step_up and step_dn high on the same edge leave the position unchanged.
- R10: Priority on one edge is direct write first, then a completing transfer, then a step. A step on an edge with a write or a completing transfer is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Direct write strobe |
| wr_data | input | 6 | Direct write value |
| xfr_req | input | 1 | Transfer-load request strobe |
| xfr_data | input | 6 | Data register value to load after the delay |
| step_up | input | 1 | Move one segment toward the high end |
| step_dn | input | 1 | Move one segment toward the low end |
| wiper_pos | output | 6 | Current wiper position |
| tap_en | output | 64 | One-hot tap switch enables |

## Verification
The bench counts edges around each transfer load. It confirms that the position stays at its old value on every edge before the settling edge and changes on that edge. A design with an off-by-one delay therefore shows the new value one cycle early or late.

It drives steps at 63 and 0. A wrapping counter would jump to the opposite end, which would switch the wiper across the whole chain.

It covers three collisions on one edge:
- a write issued while a transfer is pending, where a design that keeps the transfer alive overwrites the written value later;
- a second transfer request that must restart the delay;
- a step on the edge where a transfer completes, where a design with the wrong priority ends one position off.

The one-hot pattern is compared against the position after every operation, so a decoder whose tap order is reversed, or which lets two bits overlap, is caught.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    localparam int POS_W_DEF  = 6;
    localparam int SETTLE_DEF = 4;

    // Source chosen for the next position value, in priority order.
    typedef enum logic [2:0] {
        SRC_HOLD  = 3'd0,
        SRC_WRITE = 3'd1,
        SRC_XFR   = 3'd2,
        SRC_UP    = 3'd3,
        SRC_DN    = 3'd4
    } wiper_src_e;

    typedef struct packed {
        logic wr;
        logic fire;
        logic up;
        logic dn;
    } wiper_req_t;

    function automatic wiper_src_e pick_src(input wiper_req_t r);
        if (r.wr)             return SRC_WRITE;
        if (r.fire)           return SRC_XFR;
        if (r.up && !r.dn)    return SRC_UP;
        if (r.dn && !r.up)    return SRC_DN;
        return SRC_HOLD;
    endfunction

endpackage

// File: rtl/wiper_settle_timer.sv
module wiper_settle_timer
    import wiper_pkg::*;
#(
    parameter int POS_W      = POS_W_DEF,
    parameter int SETTLE_CYC = SETTLE_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [POS_W-1:0] req_data,
    input  logic             cancel,
    output logic             fire,
    output logic [POS_W-1:0] fire_data,
    output logic             pending
);
    localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [POS_W-1:0] data_q;
    logic             pend_q;

    assign fire      = pend_q && (cnt_q == '0) && !cancel && !req;
    assign fire_data = data_q;
    assign pending   = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            data_q <= '0;
        end else if (cancel) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (req) begin
            pend_q <= 1'b1;
            cnt_q  <= CNT_INIT;
            data_q <= req_data;
        end else if (pend_q) begin
            if (cnt_q == '0) begin
                pend_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R6: a cancel drops any pending transfer
    a_r6_cancel_clears: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !pend_q);
    // R5: a request always (re)arms the timer
    a_r5_req_arms: assert property (@(posedge clk) disable iff (rst)
        (req && !cancel) |=> pend_q);

endmodule

// File: rtl/wiper_counter.sv
module wiper_counter
    import wiper_pkg::*;
#(
    parameter int POS_W = POS_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [POS_W-1:0] wr_data,
    input  logic             fire,
    input  logic [POS_W-1:0] fire_data,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] pos_d
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    wiper_req_t req;
    wiper_src_e src;

    always_comb begin
        req      = '0;
        req.wr   = wr_valid;
        req.fire = fire;
        req.up   = step_up;
        req.dn   = step_dn;
        src      = pick_src(req);
    end

    always_comb begin
        unique case (src)
            SRC_WRITE: pos_d = wr_data;
            SRC_XFR:   pos_d = fire_data;
            SRC_UP:    pos_d = (pos_q == POS_MAX) ? pos_q : pos_q + 1'b1;
            SRC_DN:    pos_d = (pos_q == '0) ? pos_q : pos_q - 1'b1;
            default:   pos_d = pos_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else     pos_q <= pos_d;
    end

    a_r8_sat_high: assert property (@(posedge clk) disable iff (rst)
        (pos_q == POS_MAX && step_up && !step_dn && !wr_valid && !fire) |=> pos_q == POS_MAX);
    a_r8_sat_low: assert property (@(posedge clk) disable iff (rst)
        (pos_q == '0 && step_dn && !step_up && !wr_valid && !fire) |=> pos_q == '0);
    a_r7_step_up: assert property (@(posedge clk) disable iff (rst)
        (pos_q != POS_MAX && step_up && !step_dn && !wr_valid && !fire)
        |=> pos_q == $past(pos_q) + 1'b1);
    a_r9_both_hold: assert property (@(posedge clk) disable iff (rst)
        (step_up && step_dn && !wr_valid && !fire) |=> $stable(pos_q));
    a_r3_write: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> pos_q == $past(wr_data));

endmodule

// File: rtl/wiper_tap_decoder.sv
module wiper_tap_decoder
    import wiper_pkg::*;
#(
    parameter int POS_W = POS_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [POS_W-1:0]      pos_d,
    output logic [2**POS_W-1:0]   tap_q
);
    localparam int TAPS = 2**POS_W;

    logic [TAPS-1:0] tap_d;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign tap_d[k] = (pos_d == POS_W'(k));
    end

    always_ff @(posedge clk) begin
        if (rst) tap_q <= TAPS'(1);
        else     tap_q <= tap_d;
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot(tap_q));

endmodule

// File: rtl/wiper_tap_unit.sv
module wiper_tap_unit
    import wiper_pkg::*;
#(
    parameter int POS_W      = POS_W_DEF,
    parameter int SETTLE_CYC = SETTLE_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_valid,
    input  logic [POS_W-1:0]    wr_data,
    input  logic                xfr_req,
    input  logic [POS_W-1:0]    xfr_data,
    input  logic                step_up,
    input  logic                step_dn,
    output logic [POS_W-1:0]    wiper_pos,
    output logic [2**POS_W-1:0] tap_en
);
    logic             fire;
    logic [POS_W-1:0] fire_data;
    logic             pending;
    logic [POS_W-1:0] pos_d;

    wiper_settle_timer #(.POS_W(POS_W), .SETTLE_CYC(SETTLE_CYC)) i_timer (
        .clk       (clk),
        .rst       (rst),
        .req       (xfr_req),
        .req_data  (xfr_data),
        .cancel    (wr_valid),
        .fire      (fire),
        .fire_data (fire_data),
        .pending   (pending)
    );

    wiper_counter #(.POS_W(POS_W)) i_counter (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .fire      (fire),
        .fire_data (fire_data),
        .step_up   (step_up),
        .step_dn   (step_dn),
        .pos_q     (wiper_pos),
        .pos_d     (pos_d)
    );

    wiper_tap_decoder #(.POS_W(POS_W)) i_decoder (
        .clk   (clk),
        .rst   (rst),
        .pos_d (pos_d),
        .tap_q (tap_en)
    );

    // R1: reset result
    a_r1_reset_pos: assert property (@(posedge clk)
        rst |=> (wiper_pos == '0 && tap_en[0] && !pending));
    // R2: enabled tap tracks the position register
    a_r2_tap_match: assert property (@(posedge clk) disable iff (rst)
        tap_en[wiper_pos]);
    // R4: a waiting transfer leaves the position alone
    a_r4_hold_pending: assert property (@(posedge clk) disable iff (rst)
        (pending && !fire && !wr_valid && !step_up && !step_dn) |=> $stable(wiper_pos));
    // R10: completing transfer beats a step
    a_r10_fire_wins: assert property (@(posedge clk) disable iff (rst)
        (fire && !wr_valid) |=> wiper_pos == $past(fire_data));

endmodule

// File: tb/test_wiper_tap_unit.sv
module test_wiper_tap_unit;
    localparam int CLK_PERIOD = 10;
    localparam int POS_W  = 6;
    localparam int TAPS   = 64;
    localparam int SETTLE = 4;

    // op: 0 none, 1 write, 2 up, 3 down, 4 both
    typedef struct packed {
        logic [2:0]       op;
        logic [POS_W-1:0] data;
        logic [POS_W-1:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 6'd10, 6'd10}, '{3'd2, 6'd0, 6'd11}, '{3'd2, 6'd0, 6'd12},
        '{3'd3, 6'd0, 6'd11},  '{3'd4, 6'd0, 6'd11}, '{3'd0, 6'd0, 6'd11},
        '{3'd1, 6'd62, 6'd62}, '{3'd2, 6'd0, 6'd63}, '{3'd2, 6'd0, 6'd63},
        '{3'd3, 6'd0, 6'd62},  '{3'd1, 6'd1, 6'd1},  '{3'd3, 6'd0, 6'd0},
        '{3'd3, 6'd0, 6'd0},   '{3'd4, 6'd0, 6'd0},  '{3'd2, 6'd0, 6'd1},
        '{3'd1, 6'd0, 6'd0}
    };

    logic clk = 1'b0;
    logic rst;
    logic wr_valid, xfr_req, step_up, step_dn;
    logic [POS_W-1:0] wr_data, xfr_data;
    logic [POS_W-1:0] wiper_pos;
    logic [TAPS-1:0]  tap_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_tap_unit #(.POS_W(POS_W), .SETTLE_CYC(SETTLE)) i_wiper_tap_unit (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .xfr_req(xfr_req), .xfr_data(xfr_data), .step_up(step_up),
        .step_dn(step_dn), .wiper_pos(wiper_pos), .tap_en(tap_en)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        wr_valid = 0; xfr_req = 0; step_up = 0; step_dn = 0;
    endtask

    task automatic check_pos(input string req, input logic [POS_W-1:0] exp);
        logic [TAPS-1:0] exp_tap;
        exp_tap = '0;
        exp_tap[exp] = 1'b1;
        checks++;
        if (wiper_pos !== exp) begin
            errors++;
            $display("FAIL %s: wiper_pos actual %0d expected %0d", req, wiper_pos, exp);
        end
        checks++;
        if (tap_en !== exp_tap) begin
            errors++;
            $display("FAIL R2 (%s): tap_en actual %h expected %h", req, tap_en, exp_tap);
        end
    endtask

    task automatic do_write(input logic [POS_W-1:0] v);
        wr_valid = 1; wr_data = v; tick(); idle();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        wr_data = '0; xfr_data = '0;
        rst = 1;
        @(negedge clk);
        tick(); tick();
        rst = 0;
        check_pos("R1", 6'd0);

        // Table walk: R3, R7, R8, R9
        for (int i = 0; i < NV; i++) begin
            idle();
            case (VECS[i].op)
                3'd1: begin wr_valid = 1; wr_data = VECS[i].data; end
                3'd2: step_up = 1;
                3'd3: step_dn = 1;
                3'd4: begin step_up = 1; step_dn = 1; end
                default: ;
            endcase
            tick();
            idle();
            check_pos("R3/R7/R8/R9 table", VECS[i].exp);
        end

        // R4: transfer delay, exact edge
        do_write(6'd5);
        xfr_req = 1; xfr_data = 6'd40; tick(); idle();
        check_pos("R4 early", 6'd5);
        for (int k = 1; k < SETTLE; k++) begin
            tick();
            check_pos("R4 early", 6'd5);
        end
        tick();
        check_pos("R4 load", 6'd40);

        // R10: step before completion applies, step on completion edge discarded
        do_write(6'd5);
        xfr_req = 1; xfr_data = 6'd20; tick(); idle();
        step_up = 1; tick(); idle();
        check_pos("R10 step while pending", 6'd6);
        for (int k = 2; k < SETTLE; k++) tick();
        step_up = 1; tick(); idle();
        check_pos("R10 completion wins", 6'd20);

        // R5: second request restarts the delay
        do_write(6'd3);
        xfr_req = 1; xfr_data = 6'd30; tick(); idle();
        tick();
        xfr_req = 1; xfr_data = 6'd44; tick(); idle();
        for (int k = 1; k < SETTLE; k++) begin
            tick();
            check_pos("R5 restarted", 6'd3);
        end
        tick();
        check_pos("R5 new value", 6'd44);

        // R6: write cancels pending transfer
        xfr_req = 1; xfr_data = 6'd50; tick(); idle();
        do_write(6'd7);
        check_pos("R6 write", 6'd7);
        for (int k = 0; k < SETTLE + 3; k++) tick();
        check_pos("R6 cancelled", 6'd7);

        // R1: reset mid-transfer
        do_write(6'd33);
        xfr_req = 1; xfr_data = 6'd9; tick(); idle();
        rst = 1; tick(); rst = 0;
        check_pos("R1 reset", 6'd0);
        for (int k = 0; k < SETTLE + 2; k++) tick();
        check_pos("R1 pending dropped", 6'd0);

        // R8: high end reached by stepping
        do_write(6'd61);
        for (int k = 0; k < 4; k++) begin step_up = 1; tick(); idle(); end
        check_pos("R8 high", 6'd63);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule